// File: doc/BRIEF.md
# Iterative Fibonacci Calculator

This block computes the Fibonacci number of an unsigned index by repeated addition. A caller waits for `ready`, pulses `start` for one cycle with the index on `n_in`, and later sees a one-cycle `done` strobe with the answer on `result`. The sequence starts with fib(0) = 0 and fib(1) = 1. Each later term is the sum of the two terms before it.

A three-state controller (idle, run, finish) drives a datapath. The datapath holds the two most recent terms and a counter of the steps that remain. An index of 0 or 1 leaves the run state on its first cycle. A larger index n adds one term per cycle until its count reaches 1. The result is truncated to the result width, so the sum wraps. While a computation is under way, the block ignores `start`.

Top module: `fib_calc`

## Requirements
- R1: While reset is high and after it is released, `ready` is 1, `done` is 0 and `result` is 0.
- R2: `ready` is 1 exactly while the block is idle. A `start` sampled while `ready` is 1 is accepted, and `ready` is 0 in the following cycle.
- R3: An accepted index of 0 gives `done` = 1 one cycle after the accepting edge, with `result` = 0.
- R4: An accepted index of 1 gives `done` = 1 one cycle after the accepting edge, with `result` = 1.
- R5: An accepted index n of 2 or more gives `done` = 1 exactly n cycles after the accepting edge, with `result` = fib(n). `done` stays 0 during all earlier cycles.
- R6: The addition wraps modulo 2 to the power of the result width. With the default widths, index 31 yields 297693.
- R7: `done` is high for exactly one cycle. In the next cycle `ready` is 1.
- R8: A `start` pulse while `ready` is 0 is ignored. The timing and value of the running computation are unchanged, and no new computation begins.
- R9: After `done`, `result` keeps its value for as long as no new `start` is accepted.
- R10: `ready` and `done` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Request pulse, sampled while idle |
| n_in | input | NW | Index of the term to compute |
| ready | output | 1 | High while idle and able to accept work |
| done | output | 1 | One-cycle completion strobe |
| result | output | RW | Computed term, wrapped to RW bits |

## Verification
The bench counts rising edges from the edge that samples `start`. For indices 0 and 1, `done` and the value are due one edge later. For a larger index n, they are due n edges later. `ready` comes back one edge after `done`. Every check samples at the falling edge that follows the edge on which a value is due. In every earlier cycle the bench confirms that `done` is 0, so a strobe that arrives early or late counts as a failure. Start pulses injected at random during a computation must leave that timing untouched, and the held result is checked again during an idle cycle afterwards.

// File: rtl/fib_pkg.sv
package fib_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } fib_state_e;

    typedef enum logic [1:0] {
        DP_HOLD  = 2'd0,
        DP_LOAD  = 2'd1,
        DP_CLEAR = 2'd2,
        DP_STEP  = 2'd3
    } dp_op_e;
endpackage

// File: rtl/fib_ctrl.sv
module fib_ctrl
    import fib_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   cnt_zero,
    input  logic   cnt_one,
    output dp_op_e op,
    output logic   ready,
    output logic   done
);
    typedef struct packed {
        fib_state_e state;
    } ctrl_regs_t;

    ctrl_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        op     = DP_HOLD;
        unique case (regs_q.state)
            ST_IDLE: begin
                if (start) begin
                    op           = DP_LOAD;
                    regs_d.state = ST_RUN;
                end
            end
            ST_RUN: begin
                if (cnt_zero) begin
                    op           = DP_CLEAR;
                    regs_d.state = ST_FIN;
                end else if (cnt_one) begin
                    regs_d.state = ST_FIN;
                end else begin
                    op = DP_STEP;
                end
            end
            ST_FIN:  regs_d.state = ST_IDLE;
            default: regs_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) regs_q <= '{state: ST_IDLE};
        else     regs_q <= regs_d;
    end

    assign ready = (regs_q.state == ST_IDLE);
    assign done  = (regs_q.state == ST_FIN);

    // R2: an accepted request leaves idle on the next cycle
    a_r2_accept: assert property (@(posedge clk) disable iff (rst)
        ready && start |=> !ready && !done);
    // R7: the finish strobe lasts one cycle and is followed by idle
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && ready);
endmodule

// File: rtl/fib_dp.sv
module fib_dp
    import fib_pkg::*;
#(
    parameter int NW = 5,
    parameter int RW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  dp_op_e        op,
    input  logic [NW-1:0] n_in,
    output logic          cnt_zero,
    output logic          cnt_one,
    output logic [RW-1:0] result
);
    localparam logic [NW-1:0] CNT_ONE = NW'(1);
    localparam logic [RW-1:0] TERM_ONE = RW'(1);

    typedef struct packed {
        logic [NW-1:0] cnt;
        logic [RW-1:0] prev;
        logic [RW-1:0] curr;
    } dp_regs_t;

    dp_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        unique case (op)
            DP_LOAD: begin
                regs_d.cnt  = n_in;
                regs_d.prev = '0;
                regs_d.curr = TERM_ONE;
            end
            DP_CLEAR: regs_d.curr = '0;
            DP_STEP: begin
                regs_d.curr = regs_q.curr + regs_q.prev;
                regs_d.prev = regs_q.curr;
                regs_d.cnt  = regs_q.cnt - CNT_ONE;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign cnt_zero = (regs_q.cnt == '0);
    assign cnt_one  = (regs_q.cnt == CNT_ONE);
    assign result   = regs_q.curr;

    // R5: each step moves the newest term into the older slot
    a_r5_shift: assert property (@(posedge clk) disable iff (rst)
        op == DP_STEP |=> regs_q.prev == $past(regs_q.curr));
endmodule

// File: rtl/fib_calc.sv
module fib_calc
    import fib_pkg::*;
#(
    parameter int NW = 5,
    parameter int RW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [NW-1:0] n_in,
    output logic          ready,
    output logic          done,
    output logic [RW-1:0] result
);
    dp_op_e op;
    logic   cnt_zero;
    logic   cnt_one;

    fib_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one),
        .op       (op),
        .ready    (ready),
        .done     (done)
    );

    fib_dp #(.NW(NW), .RW(RW)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .n_in     (n_in),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one),
        .result   (result)
    );

    // R10: idle and finish never overlap
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ready && done));
    // R9: the result is held while idle without a request
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        ready && !start |=> $stable(result));
endmodule

// File: tb/tb_fib_calc.sv
module tb_fib_calc;
    localparam int NW = 5;
    localparam int RW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [NW-1:0] n_in = '0;
    logic          ready, done;
    logic [RW-1:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    fib_calc #(.NW(NW), .RW(RW)) dut (
        .clk(clk), .rst(rst), .start(start), .n_in(n_in),
        .ready(ready), .done(done), .result(result)
    );

    always #4 clk = ~clk;

    function automatic logic [RW-1:0] fib_ref(input int n);
        logic [RW-1:0] a = '0;
        logic [RW-1:0] b = RW'(1);
        logic [RW-1:0] t;
        if (n == 0) return '0;
        for (int i = 1; i < n; i++) begin
            t = a + b;
            a = b;
            b = t;
        end
        return b;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_one(input int n, input bit poke);
        int lat;
        logic [RW-1:0] exp_v;
        string tag;
        lat   = (n < 2) ? 1 : n;
        exp_v = fib_ref(n);
        tag   = (n == 0) ? "R3" : (n == 1) ? "R4" : (n == 31) ? "R6" : "R5";
        @(negedge clk);
        check(ready == 1'b1, "R2 ready before start", int'(ready), 1);
        start = 1'b1;
        n_in  = NW'(n);
        @(negedge clk);
        start = 1'b0;
        check(ready == 1'b0, "R2 ready after accept", int'(ready), 0);
        for (int c = 0; c < lat; c++) begin
            if (done !== 1'b0) check(0, "R5 early done", int'(done), 0);
            if (poke && ($urandom % 2 == 0)) begin
                start = 1'b1;  // R8: must be ignored while busy
                n_in  = NW'($urandom);
            end
            @(negedge clk);
            start = 1'b0;
        end
        check(done == 1'b1, {tag, " done timing"}, int'(done), 1);
        check(result == exp_v, {tag, " value"}, int'(result), int'(exp_v));
        if (poke) begin
            start = 1'b1;  // R8: request during finish cycle ignored
            n_in  = NW'($urandom);
        end
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0 && ready == 1'b1, "R7 single strobe then idle",
              int'({done, ready}), 1);
        check(!(done && ready), "R10 exclusive", int'({done, ready}), 1);
        @(negedge clk);
        check(ready == 1'b1, "R8 busy request ignored", int'(ready), 1);
        check(result == exp_v, "R9 held result", int'(result), int'(exp_v));
    endtask

    initial begin
        void'($urandom(32'd1234));
        #3;
        check(ready == 1'b1 && done == 1'b0 && result == '0, "R1 in reset",
              int'(result), 0);
        #20;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ready == 1'b1 && done == 1'b0 && result == '0, "R1 after reset",
              int'(result), 0);
        run_one(0, 1'b0);
        run_one(1, 1'b0);
        run_one(2, 1'b0);
        run_one(3, 1'b1);
        run_one(31, 1'b1);
        run_one(30, 1'b0);
        run_one(0, 1'b1);
        for (int k = 0; k < 40; k++) run_one(int'($urandom % 32), 1'b1);
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule